// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a processor request port and a slower word-wide memory port. It keeps a small two-way set-associative store of four-word lines, each way of each set carrying a tag, a valid flag and a modified flag, plus one recency bit per set. A request whose line is resident completes locally in one cycle. Stores touch only the cached copy, so memory gets new data only when a modified line has to make room.

A request that finds no resident line raises `busy` and starts the miss sequence. First a replacement way is chosen: an empty way if the set has one, otherwise the way used less recently. If that way holds modified data, its four words go back to memory. The line containing the requested word is then read in four single-word beats, and the original load or store is finished as if it had hit. The processor issues a request as a one-cycle pulse on `req_valid`, and only while `busy` is low. The memory port uses a request/acknowledge handshake: it presents one address at a time and advances on each `mem_ack`.

Top module: `assoc_wb_cache`

## Requirements
- R1: A word address is split as bits [1:0] = word within the line, the next INDEX_W bits = set, and the remaining upper bits = tag. All four words of one line are served by a single fill.
- R2: A request hits when either way of the addressed set is valid and holds the same tag. Both ways are compared in the same cycle. `resp_valid` (and `resp_rdata` for a load) appears one cycle after the request, `busy` stays low and the memory port stays idle.
- R3: On a miss the line is read with four `mem_req` beats (`mem_we` low) at offsets 0, 1, 2, 3 in that order. The requested load then returns the memory word.
- R4: A store that hits updates only the cached word and marks the line modified. The memory port issues no write.
- R5: Memory is written only when a modified line is replaced. Its four words go out (`mem_we` high, offsets 0 to 3) at the old line address before the fill begins. Replacing an unmodified line writes nothing.
- R6: The replacement way is an invalid way if one exists (way 0 before way 1). Otherwise it is the way of the set used less recently. Recency is updated on every hit and on every fill.
- R7: `busy` rises in the cycle after a miss is accepted and falls in the same cycle that `resp_valid` rises. A `req_valid` pulse while `busy` is high is ignored.
- R8: Reset clears every valid and modified flag. Afterwards `busy`, `resp_valid` and `mem_req` are low, every access misses, and stores made before the reset are never written back.
- R9: A store that misses allocates the line: the line is filled first, then the word is merged and the line is marked modified.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` hold steady. Each `mem_ack` completes exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One-cycle request pulse, accepted when busy is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | Request completed this cycle |
| resp_rdata | output | DATA_W | Load data, valid with resp_valid |
| busy | output | 1 | Miss in progress; new requests are ignored |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | ADDR_W | Word address of the current beat |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory completed the current beat |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |

## Verification
The bench builds the block with ADDR_W=10, DATA_W=16 and INDEX_W=2. That gives only four sets and a six-bit tag, so a few addresses that differ only in tag can fill a set and force replacements. With only two ways per set, the order of replacements (empty way first, then the less recent way, then a modified victim) can be driven and observed directly through memory-beat counts. The 1024-word space is also small enough for the bench to hold a full behavioural memory and a shadow copy of the expected contents.

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = 2;
  localparam int WORDS = 1 << OFF_W;
  localparam int SETS  = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_DONE} st_t;

  st_t               state;
  logic [DATA_W-1:0] data_q  [2][SETS][WORDS];
  logic [TAG_W-1:0]  tag_q   [2][SETS];
  logic [SETS-1:0]   valid_q [2];
  logic [SETS-1:0]   dirty_q [2];
  logic [SETS-1:0]   lru_q;

  logic              r_write, r_way;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [OFF_W-1:0]  beat;

  logic [ADDR_W-1:0]  acc_addr;
  logic [TAG_W-1:0]   a_tag;
  logic [INDEX_W-1:0] a_idx, r_idx;
  logic [OFF_W-1:0]   a_off;
  logic [TAG_W-1:0]   r_tag;
  logic hit0, hit1, hit, hway, vic, accept, do_access, acc_write, last_beat;
  logic [DATA_W-1:0]  acc_wdata;

  assign acc_addr  = (state == S_IDLE) ? req_addr : r_addr;
  assign acc_write = (state == S_IDLE) ? req_write : r_write;
  assign acc_wdata = (state == S_IDLE) ? req_wdata : r_wdata;
  assign a_tag = acc_addr[ADDR_W-1 -: TAG_W];
  assign a_idx = acc_addr[OFF_W +: INDEX_W];
  assign a_off = acc_addr[OFF_W-1:0];
  assign r_tag = r_addr[ADDR_W-1 -: TAG_W];
  assign r_idx = r_addr[OFF_W +: INDEX_W];

  assign hit0 = valid_q[0][a_idx] && (tag_q[0][a_idx] == a_tag);
  assign hit1 = valid_q[1][a_idx] && (tag_q[1][a_idx] == a_tag);
  assign hit  = hit0 | hit1;
  assign hway = hit1;
  assign vic  = !valid_q[0][a_idx] ? 1'b0 :
                !valid_q[1][a_idx] ? 1'b1 : lru_q[a_idx];

  assign accept    = (state == S_IDLE) && req_valid;
  assign do_access = (accept && hit) || (state == S_DONE);
  assign last_beat = mem_ack && (beat == OFF_W'(WORDS - 1));

  assign busy      = (state != S_IDLE);
  assign mem_req   = (state == S_WB) || (state == S_FILL);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = (state == S_WB) ? {tag_q[r_way][r_idx], r_idx, beat}
                                     : {r_tag, r_idx, beat};
  assign mem_wdata = data_q[r_way][r_idx][beat];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      valid_q    <= '{default: '0};
      dirty_q    <= '{default: '0};
      lru_q      <= '0;
      resp_valid <= 1'b0;
      beat       <= '0;
      r_write    <= 1'b0;
      r_way      <= 1'b0;
      r_addr     <= '0;
      r_wdata    <= '0;
    end else begin
      resp_valid <= do_access;
      case (state)
        S_IDLE:
          if (accept && !hit) begin
            r_write <= req_write;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_way   <= vic;
            beat    <= '0;
            state   <= (valid_q[vic][a_idx] && dirty_q[vic][a_idx]) ? S_WB : S_FILL;
          end
        S_WB:
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (last_beat) begin
              dirty_q[r_way][r_idx] <= 1'b0;
              state <= S_FILL;
            end
          end
        S_FILL:
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (last_beat) begin
              valid_q[r_way][r_idx] <= 1'b1;
              lru_q[r_idx] <= ~r_way;
              state <= S_DONE;
            end
          end
        default: state <= S_IDLE;
      endcase
      if (do_access) begin
        lru_q[a_idx] <= ~hway;
        if (acc_write) dirty_q[hway][a_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && mem_ack) begin
      data_q[r_way][r_idx][beat] <= mem_rdata;
      if (last_beat) tag_q[r_way][r_idx] <= r_tag;
    end
    if (do_access) begin
      if (acc_write) data_q[hway][a_idx][a_off] <= acc_wdata;
      resp_rdata <= data_q[hway][a_idx][a_off];
    end
  end

  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit0 && hit1)); // R2
  AST_DONE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE) |-> (hit && hway == r_way)); // R3
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> dirty_q[r_way][r_idx]); // R5
  AST_BUSY_ENDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> resp_valid); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
endmodule

// File: tb/sim_assoc_wb_cache.sv
module sim_assoc_wb_cache;
  localparam int AW = 10, DW = 16, IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic resp_valid, busy, mem_req, mem_we;
  logic [DW-1:0] resp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  assoc_wb_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [DW-1:0] mem   [1<<AW];
  logic [DW-1:0] ref_m [1<<AW];
  int checks = 0, fails = 0;
  int rd_beats = 0, wr_beats = 0, order_err = 0;
  typedef struct packed { logic wr; logic [DW-1:0] d; } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int t, int i, int o);
    return {t[5:0], i[1:0], o[1:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] <= mem_wdata;
    end else mem_ack <= 1'b0;
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) begin
        if (mem_addr[1:0] != wr_beats[1:0]) order_err++;
        wr_beats++;
      end else begin
        if (mem_addr[1:0] != rd_beats[1:0]) order_err++;
        rd_beats++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q.size() == 0) chk(0, "R7", "response with nothing outstanding", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        if (!e.wr) chk(resp_rdata == e.d, "R2 R3 R9", "load data", int'(resp_rdata), int'(e.d));
      end
    end
  end

  task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, int exp_rd, int exp_wr,
                        string req, bit poke = 0, logic [AW-1:0] poke_a = '0);
    int rd0, wr0;
    bit first;
    @(negedge clk);
    while (busy) @(negedge clk);
    rd0 = rd_beats; wr0 = wr_beats;
    q.push_back({wr, wr ? d : ref_m[a]});
    if (wr) ref_m[a] = d;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    first = resp_valid && !busy;
    if (exp_rd == 0) chk(first, req, "hit answers next cycle with busy low", int'(first), 1);
    else chk(!resp_valid && busy, "R7", "busy after miss accepted", int'(busy), 1);
    if (poke && busy) begin
      req_valid = 1'b1; req_write = 1'b0; req_addr = poke_a;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(rd_beats - rd0 == exp_rd, req, "fill beats", rd_beats - rd0, exp_rd);
    chk(wr_beats - wr0 == exp_wr, req, "write-back beats", wr_beats - wr0, exp_wr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && !resp_valid && !mem_req, "R8", "idle outputs after reset",
        {busy, resp_valid, mem_req}, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      mem[i]   = DW'(i * 7 + 3);
      ref_m[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && !resp_valid && !mem_req, "R8", "idle outputs after reset",
        {busy, resp_valid, mem_req}, 0);

    access(0, mk(1,0,2), 0, 4, 0, "R3");            // cold miss fills line
    access(0, mk(1,0,3), 0, 0, 0, "R1");            // same line, hit
    access(1, mk(1,0,1), 16'hBEEF, 0, 0, "R4");     // store hit, no memory write
    access(0, mk(1,0,1), 0, 0, 0, "R4");            // reads back stored word
    access(0, mk(2,0,0), 0, 4, 0, "R6");            // empty way used
    access(0, mk(1,0,0), 0, 0, 0, "R2");            // both tags resident
    access(0, mk(3,0,0), 0, 4, 0, "R6");            // evicts tag2 (older), clean: no writes
    access(0, mk(1,0,2), 0, 0, 0, "R6");            // tag1 survived
    access(0, mk(2,0,0), 0, 4, 0, "R5");            // evicts tag3, clean
    access(0, mk(2,0,1), 0, 0, 0, "R2");
    access(0, mk(4,0,0), 0, 4, 4, "R5");            // evicts dirty tag1
    chk(mem[mk(1,0,1)] == 16'hBEEF, "R5", "written-back word in memory", int'(mem[mk(1,0,1)]), 16'hBEEF);
    chk(mem[mk(1,0,3)] == ref_m[mk(1,0,3)], "R5", "clean word of line", int'(mem[mk(1,0,3)]), int'(ref_m[mk(1,0,3)]));

    access(1, mk(5,1,3), 16'h1234, 4, 0, "R9");     // store miss allocates
    access(0, mk(5,1,3), 0, 0, 0, "R9");
    access(0, mk(6,2,0), 0, 4, 0, "R7", 1, mk(7,3,0)); // request while busy ignored
    access(0, mk(7,3,0), 0, 4, 0, "R7");            // so this one still misses
    access(0, mk(8,1,0), 0, 4, 0, "R6");
    access(0, mk(9,1,0), 0, 4, 4, "R5");            // evicts dirty tag5
    chk(mem[mk(5,1,3)] == 16'h1234, "R9", "allocated store reached memory", int'(mem[mk(5,1,3)]), 16'h1234);

    access(1, mk(9,1,2), 16'h5A5A, 0, 0, "R4");
    do_reset();
    ref_m[mk(9,1,2)] = mem[mk(9,1,2)];
    access(0, mk(9,1,2), 0, 4, 0, "R8");            // misses, dirty data dropped
    access(0, mk(8,1,0), 0, 4, 0, "R8");
    access(0, mk(10,1,0), 0, 4, 0, "R6");           // evicts clean tag9 line
    access(0, mk(8,1,1), 0, 0, 0, "R6");

    repeat (4) @(negedge clk);
    chk(order_err == 0, "R10", "beat offsets in order 0..3", order_err, 0);
    chk(q.size() == 0, "R7", "every request answered once", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule